// File: doc/BRIEF.md
# Dual-Lane Serial Flash Command Front-End

This block is the slave side of a two-lane serial flash interface. Every part of a command travels two bits per serial clock on a pair of bidirectional data lines: the opcode, an optional 24-bit address and the payload. Chip select frames each command. The block oversamples the serial clock, chip select and data lines in the system clock domain and assembles bytes. It looks each opcode up in a parameter table that marks the command as read-type, modify-type, power-down entry or power-down release.

A read-type command moves to a data-out phase straight after its header. In that phase the block fetches bytes from the memory model through a simple request/response port, at incrementing addresses, and shifts them onto the lines. A modify-type command streams its payload bytes out tentatively. It commits with a one-cycle execute strobe only when chip select rises after a whole number of bytes. While the block is in deep power-down it ignores every opcode except release.

Top module: `dio_flash_frontend`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges, two per edge, with the most significant pair first and `dq_i[1]` holding the higher bit of each pair.
- R2: For table entries flagged as addressed, the three bytes after the opcode form a 24-bit address, most significant byte first. That address is reported with the execute strobe and used as the first read address.
- R3: For a read-type command, the first output pair (bits 7:6) is driven after the falling edge that follows the last header bit. One pair follows on every later falling edge. Byte k comes from a read request at address base+k, and `rd_data_i` is taken in the cycle after `rd_req_o`.
- R4: Chip select may rise after any output pair of a read. Driving stops, no strobe results, and the next frame is handled normally.
- R5: A modify-type command whose frame ends on a byte boundary raises `exec_o` for exactly one cycle. `exec_op_o`, `exec_addr_o` and `exec_len_o` (the payload byte count) are valid in that cycle.
- R6: A modify-type command whose frame ends with 1 to 3 extra pairs produces no execute strobe.
- R7: Each complete payload byte of a modify-type command pulses `wr_valid_o` with the byte on `wr_byte_o`.
- R8: `dq_oe_o` is high only during the data-out phase of a read with chip select low. It returns low within four clock cycles of chip select going high.
- R9: Opcode 0xB9, ended on a byte boundary, sets `dpd_o` and raises no execute strobe. Ended off a boundary, it has no effect.
- R10: While `dpd_o` is high, every opcode other than 0xAB is ignored: no strobe, no write byte and no driving.
- R11: Opcode 0xAB, ended on a byte boundary, clears `dpd_o`, and later commands execute again. Ended off a boundary, it leaves `dpd_o` set.
- R12: An opcode that is not in the table is ignored for the rest of its frame.
- R13: After reset, `dq_oe_o`, `exec_o`, `wr_valid_o`, `rd_req_o` and `dpd_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| dq_i | input | 2 | Data lines, input side |
| dq_o | output | 2 | Data lines, output side |
| dq_oe_o | output | 2 | Output enables of the data lines |
| rd_req_o | output | 1 | One-cycle read request to the memory model |
| rd_op_o | output | 8 | Opcode of the current read |
| rd_addr_o | output | ADDR_W | Address of the requested byte |
| rd_data_i | input | 8 | Read byte, valid the cycle after the request |
| wr_valid_o | output | 1 | Payload byte strobe for modify commands |
| wr_byte_o | output | 8 | Payload byte |
| exec_o | output | 1 | One-cycle commit strobe for modify commands |
| exec_op_o | output | 8 | Committed opcode |
| exec_addr_o | output | ADDR_W | Committed address (0 if none) |
| exec_len_o | output | LEN_W | Committed payload byte count |
| dpd_o | output | 1 | Deep power-down state |

## Verification
Some properties are checked on every cycle: the commit strobe is one cycle wide, the three strobes never overlap, and the line drivers are released once chip select has stayed high. Another per-cycle check is that power-down keeps the block silent. Byte-boundary acceptance and rejection can only be shown by the bench's frames, as can bit ordering, address assembly and read data at incrementing addresses. The same holds for read truncation and the power-down entry and release sequence, since each depends on a whole framed transaction.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAIRS  = BYTE_W / LANES;
  localparam int unsigned PCNT_W = $clog2(PAIRS);

  typedef enum logic [1:0] {K_READ, K_MODIFY, K_DPD_ENTER, K_DPD_EXIT} cmd_kind_e;

  typedef struct packed {
    logic [7:0] code;
    cmd_kind_e  kind;
    logic       has_addr;
  } cmd_entry_t;

  typedef enum logic [2:0] {ST_IDLE, ST_OP, ST_ADDR, ST_DOUT, ST_WDATA, ST_IGNORE} fe_state_e;

  function automatic cmd_entry_t ce(logic [7:0] c, cmd_kind_e k, logic a);
    cmd_entry_t e;
    e.code = c;
    e.kind = k;
    e.has_addr = a;
    return e;
  endfunction

  localparam int unsigned N_CMD = 26;

  localparam cmd_entry_t [N_CMD-1:0] DEFAULT_TABLE = '{
    ce(8'hBB, K_READ, 1'b1),      // dual fast read
    ce(8'h4B, K_READ, 1'b1),      // otp read
    ce(8'hE8, K_READ, 1'b1),      // lock read
    ce(8'h05, K_READ, 1'b0),      // status read
    ce(8'h70, K_READ, 1'b0),      // flag read
    ce(8'hB5, K_READ, 1'b0),      // nv config read
    ce(8'h85, K_READ, 1'b0),      // volatile config read
    ce(8'h65, K_READ, 1'b0),      // enhanced config read
    ce(8'h9F, K_READ, 1'b0),      // id read
    ce(8'hA2, K_MODIFY, 1'b1),    // page program
    ce(8'h42, K_MODIFY, 1'b1),    // otp program
    ce(8'h20, K_MODIFY, 1'b1),    // small erase
    ce(8'hD8, K_MODIFY, 1'b1),    // sector erase
    ce(8'hE5, K_MODIFY, 1'b1),    // lock write
    ce(8'hC7, K_MODIFY, 1'b0),    // full erase
    ce(8'h75, K_MODIFY, 1'b0),    // suspend
    ce(8'h7A, K_MODIFY, 1'b0),    // resume
    ce(8'h01, K_MODIFY, 1'b0),    // status write
    ce(8'h50, K_MODIFY, 1'b0),    // flag clear
    ce(8'h81, K_MODIFY, 1'b0),    // volatile config write
    ce(8'h61, K_MODIFY, 1'b0),    // enhanced config write
    ce(8'hB1, K_MODIFY, 1'b0),    // nv config write
    ce(8'h06, K_MODIFY, 1'b0),    // write enable
    ce(8'h04, K_MODIFY, 1'b0),    // write disable
    ce(8'hB9, K_DPD_ENTER, 1'b0),
    ce(8'hAB, K_DPD_EXIT, 1'b0)
  };
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dio_cmd_lookup.sv
module dio_cmd_lookup
  import dio_pkg::*;
#(
  parameter int unsigned N = N_CMD,
  parameter cmd_entry_t [N-1:0] TABLE = DEFAULT_TABLE
) (
  input  logic [7:0] code_i,
  output logic       hit_o,
  output cmd_kind_e  kind_o,
  output logic       has_addr_o
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = (TABLE[i].code == code_i);
  end

  always_comb begin
    hit_o      = |match;
    kind_o     = K_READ;
    has_addr_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        kind_o     = TABLE[i].kind;
        has_addr_o = TABLE[i].has_addr;
      end
    end
  end
endmodule

// File: rtl/dio_rx_shifter.sv
module dio_rx_shifter
  import dio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic [LANES-1:0] dq_i,
  output logic             byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic             aligned_o
);
  logic [PCNT_W-1:0]       pair_q;
  logic [BYTE_W-LANES-1:0] acc_q;
  logic [BYTE_W-1:0]       byte_q;
  logic                    valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q  <= '0;
      acc_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        pair_q <= '0;
      end else if (shift_i) begin
        acc_q  <= {acc_q[BYTE_W-2*LANES-1:0], dq_i};
        pair_q <= pair_q + 1'b1;
        if (pair_q == PCNT_W'(PAIRS-1)) begin
          byte_q  <= {acc_q, dq_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_valid_o = valid_q;
  assign byte_o       = byte_q;
  assign aligned_o    = (pair_q == '0);
endmodule

// File: rtl/dio_tx_shifter.sv
module dio_tx_shifter
  import dio_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              shift_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [LANES-1:0]  dq_o
);
  logic [BYTE_W-1:0] cur_q, nxt_q;
  logic [PCNT_W-1:0] cnt_q;
  logic              req_q, resp_q, fill_cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  dq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      nxt_q      <= '0;
      cnt_q      <= '0;
      req_q      <= 1'b0;
      resp_q     <= 1'b0;
      fill_cur_q <= 1'b0;
      addr_q     <= '0;
      dq_q       <= '0;
    end else if (abort_i) begin
      req_q      <= 1'b0;
      resp_q     <= 1'b0;
      fill_cur_q <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      resp_q <= req_q;
      if (req_q) addr_q <= addr_q + 1'b1;
      if (start_i) begin
        addr_q     <= base_addr_i;
        req_q      <= 1'b1;
        fill_cur_q <= 1'b1;
        cnt_q      <= '0;
      end
      if (resp_q) begin
        if (fill_cur_q) begin
          cur_q      <= rd_data_i;
          fill_cur_q <= 1'b0;
          req_q      <= 1'b1;   // prefetch the following byte
        end else begin
          nxt_q <= rd_data_i;
        end
      end
      if (shift_i) begin
        dq_q  <= cur_q[BYTE_W-1 -: LANES];
        cur_q <= {cur_q[BYTE_W-LANES-1:0], {LANES{1'b0}}};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == PCNT_W'(PAIRS-1)) begin
          cur_q <= nxt_q;
          req_q <= 1'b1;
        end
      end
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign dq_o      = dq_q;
endmodule

// File: rtl/dio_flash_frontend.sv
module dio_flash_frontend
  import dio_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned NCMD   = N_CMD,
  parameter cmd_entry_t [NCMD-1:0] CMD_TABLE = DEFAULT_TABLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic [1:0]        dq_i,
  output logic [1:0]        dq_o,
  output logic [1:0]        dq_oe_o,
  output logic              rd_req_o,
  output logic [7:0]        rd_op_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  output logic [7:0]        wr_byte_o,
  output logic              exec_o,
  output logic [7:0]        exec_op_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic [LEN_W-1:0]  exec_len_o,
  output logic              dpd_o
);
  localparam int unsigned ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int unsigned AB_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [3:0] sync_q;
  logic       sck_s, cs_s, sck_d, cs_d;
  logic [1:0] dq_s;

  dio_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, dq_i}),
    .q_o   (sync_q)
  );
  assign {sck_s, cs_s, dq_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  logic active, sck_rise, sck_fall, frame_start, frame_end;
  assign active      = ~cs_s;
  assign sck_rise    = sck_s & ~sck_d;
  assign sck_fall    = ~sck_s & sck_d;
  assign frame_start = cs_d & ~cs_s;
  assign frame_end   = ~cs_d & cs_s;

  logic       rx_valid, rx_aligned;
  logic [7:0] rx_byte;

  dio_rx_shifter u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (frame_start),
    .shift_i     (sck_rise & active),
    .dq_i        (dq_s),
    .byte_valid_o(rx_valid),
    .byte_o      (rx_byte),
    .aligned_o   (rx_aligned)
  );

  logic      lk_hit, lk_has_addr;
  cmd_kind_e lk_kind;

  dio_cmd_lookup #(.N(NCMD), .TABLE(CMD_TABLE)) u_lookup (
    .code_i    (rx_byte),
    .hit_o     (lk_hit),
    .kind_o    (lk_kind),
    .has_addr_o(lk_has_addr)
  );

  fe_state_e         state_q;
  cmd_kind_e         kind_q;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AB_W-1:0]   abyte_q;
  logic [LEN_W-1:0]  len_q;
  logic              dpd_q, exec_q, wr_valid_q, tx_start_q;
  logic [7:0]        wr_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_READ;
      op_q       <= '0;
      addr_q     <= '0;
      abyte_q    <= '0;
      len_q      <= '0;
      dpd_q      <= 1'b0;
      exec_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_byte_q  <= '0;
      tx_start_q <= 1'b0;
    end else begin
      exec_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      tx_start_q <= 1'b0;
      if (frame_start) begin
        state_q <= ST_OP;
        addr_q  <= '0;
        abyte_q <= '0;
        len_q   <= '0;
      end else if (frame_end) begin
        // commit only on a whole-byte frame
        if (state_q == ST_WDATA && rx_aligned) begin
          unique case (kind_q)
            K_MODIFY:    exec_q <= 1'b1;
            K_DPD_ENTER: dpd_q  <= 1'b1;
            K_DPD_EXIT:  dpd_q  <= 1'b0;
            default: ;
          endcase
        end
        state_q <= ST_IDLE;
      end else if (rx_valid) begin
        unique case (state_q)
          ST_OP: begin
            op_q   <= rx_byte;
            kind_q <= lk_kind;
            if (!lk_hit || (dpd_q && lk_kind != K_DPD_EXIT)) begin
              state_q <= ST_IGNORE;
            end else if (lk_has_addr) begin
              state_q <= ST_ADDR;
            end else if (lk_kind == K_READ) begin
              state_q    <= ST_DOUT;
              tx_start_q <= 1'b1;
            end else begin
              state_q <= ST_WDATA;
            end
          end
          ST_ADDR: begin
            addr_q  <= {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
            abyte_q <= abyte_q + 1'b1;
            if (abyte_q == AB_W'(ADDR_BYTES-1)) begin
              if (kind_q == K_READ) begin
                state_q    <= ST_DOUT;
                tx_start_q <= 1'b1;
              end else begin
                state_q <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (kind_q == K_MODIFY) begin
              wr_valid_q <= 1'b1;
              wr_byte_q  <= rx_byte;
              len_q      <= len_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic in_dout;
  assign in_dout = (state_q == ST_DOUT) & active;

  dio_tx_shifter #(.ADDR_W(ADDR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (tx_start_q),
    .abort_i    (cs_s),
    .shift_i    (sck_fall & in_dout),
    .base_addr_i(addr_q),
    .rd_data_i  (rd_data_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .dq_o       (dq_o)
  );

  assign dq_oe_o     = {2{in_dout}};
  assign rd_op_o     = op_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_byte_o   = wr_byte_q;
  assign exec_o      = exec_q;
  assign exec_op_o   = op_q;
  assign exec_addr_o = addr_q;
  assign exec_len_o  = len_q;
  assign dpd_o       = dpd_q;
endmodule

// File: rtl/dio_flash_frontend_chk.sv
module dio_flash_frontend_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [1:0] dq_oe_o,
  input logic       rd_req_o,
  input logic       wr_valid_o,
  input logic       exec_o,
  input logic       dpd_o
);
  a_r5_exec_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exec_o, wr_valid_o, rd_req_o}));

  a_r8_oe_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> (dq_oe_o == 2'b00));

  a_r10_dpd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_o |-> (!exec_o && !wr_valid_o && !rd_req_o && dq_oe_o == 2'b00));

  a_r7_no_write_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (dq_oe_o == 2'b00));
endmodule

bind dio_flash_frontend dio_flash_frontend_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .dq_oe_o   (dq_oe_o),
  .rd_req_o  (rd_req_o),
  .wr_valid_o(wr_valid_o),
  .exec_o    (exec_o),
  .dpd_o     (dpd_o)
);

// File: tb/tb_dio_flash_frontend.sv
module tb_dio_flash_frontend;
  localparam int H = 10;  // clk cycles per SCK half period

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  dq_drv = 2'b00;
  logic [1:0]  dq_o, dq_oe_o;
  logic        rd_req_o, wr_valid_o, exec_o, dpd_o;
  logic [7:0]  rd_op_o, wr_byte_o, exec_op_o;
  logic [23:0] rd_addr_o, exec_addr_o;
  logic [15:0] exec_len_o;
  logic [7:0]  mem_q = 8'h00;

  always #2 clk = ~clk;

  dio_flash_frontend dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .dq_i(dq_drv),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .rd_req_o(rd_req_o), .rd_op_o(rd_op_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(mem_q), .wr_valid_o(wr_valid_o),
    .wr_byte_o(wr_byte_o), .exec_o(exec_o), .exec_op_o(exec_op_o),
    .exec_addr_o(exec_addr_o), .exec_len_o(exec_len_o), .dpd_o(dpd_o)
  );

  // memory model: byte = addr[7:0] ^ opcode, one cycle after request
  always @(posedge clk) if (rd_req_o) mem_q <= rd_addr_o[7:0] ^ rd_op_o;

  int n_cmp = 0, n_bad = 0;
  int exec_cnt = 0, wr_cnt = 0;
  logic [7:0]  last_op = 8'h00, last_wr = 8'h00;
  logic [23:0] last_addr = 24'h0;
  logic [15:0] last_len = 16'h0;
  logic        oe_seen = 1'b0;
  logic        done = 1'b0;

  always @(negedge clk) begin
    if (exec_o) begin
      exec_cnt++;
      last_op = exec_op_o; last_addr = exec_addr_o; last_len = exec_len_o;
    end
    if (wr_valid_o) begin wr_cnt++; last_wr = wr_byte_o; end
    if (|dq_oe_o) oe_seen = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer_pair(input logic [1:0] tx, output logic [1:0] rx);
    dq_drv = tx;
    repeat (H) @(negedge clk);
    rx = (dq_oe_o == 2'b11) ? dq_o : 2'bxx;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [1:0] junk;
    for (int p = 3; p >= 0; p--) xfer_pair(b[2*p +: 2], junk);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic [1:0] r;
    for (int p = 3; p >= 0; p--) begin
      xfer_pair(2'b00, r);
      b[2*p +: 2] = r;
    end
  endtask

  // cls: 0 read, 1 modify, 2 unknown
  task automatic run_frame(input logic [7:0] op, input logic ha, input logic [1:0] cls,
                           input logic [23:0] ad, input int nb, input int extra,
                           input logic drive);
    logic [7:0]  rb;
    logic [1:0]  junk;
    logic [23:0] a2;
    @(negedge clk);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    repeat (6) @(negedge clk);
    send_byte(op);
    if (ha) begin
      send_byte(ad[23:16]); send_byte(ad[15:8]); send_byte(ad[7:0]);
    end
    for (int k = 0; k < nb; k++) begin
      if (cls == 2'd0) begin
        read_byte(rb);
        a2 = ad + 24'(k);
        if (drive) chk("R3 read byte", {24'h0, rb}, {24'h0, a2[7:0] ^ op});
      end else begin
        send_byte(8'h5A + 8'(k));
      end
    end
    for (int e = 0; e < extra; e++) xfer_pair(2'b10, junk);
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic        ha;
    logic [1:0]  cls;
    logic [23:0] ad;
    logic [3:0]  nb;
    logic [1:0]  extra;
    logic        exp_exec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h06, 1'b0, 2'd1, 24'h000000, 4'd0, 2'd0, 1'b1},
    '{8'hA2, 1'b1, 2'd1, 24'h123456, 4'd3, 2'd0, 1'b1},
    '{8'hA2, 1'b1, 2'd1, 24'h000010, 4'd2, 2'd1, 1'b0},
    '{8'hD8, 1'b1, 2'd1, 24'hABCDEF, 4'd0, 2'd0, 1'b1},
    '{8'hC7, 1'b0, 2'd1, 24'h000000, 4'd0, 2'd2, 1'b0},
    '{8'hBB, 1'b1, 2'd0, 24'h0000FE, 4'd3, 2'd0, 1'b0},
    '{8'h05, 1'b0, 2'd0, 24'h000000, 4'd2, 2'd0, 1'b0},
    '{8'h9F, 1'b0, 2'd0, 24'h000000, 4'd1, 2'd1, 1'b0},
    '{8'h04, 1'b0, 2'd1, 24'h000000, 4'd0, 2'd0, 1'b1},
    '{8'h11, 1'b0, 2'd2, 24'h000000, 4'd1, 2'd0, 1'b0},
    '{8'h50, 1'b0, 2'd1, 24'h000000, 4'd0, 2'd0, 1'b1},
    '{8'h20, 1'b1, 2'd1, 24'h000800, 4'd0, 2'd3, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e0, w0;
    repeat (5) @(negedge clk);
    // R13 reset state
    chk("R13 oe", {30'h0, dq_oe_o}, 32'h0);
    chk("R13 exec", {31'h0, exec_o}, 32'h0);
    chk("R13 dpd", {31'h0, dpd_o}, 32'h0);
    chk("R13 strobes", {30'h0, rd_req_o, wr_valid_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      e0 = exec_cnt; w0 = wr_cnt;
      run_frame(VECS[i].op, VECS[i].ha, VECS[i].cls, VECS[i].ad,
                int'(VECS[i].nb), int'(VECS[i].extra), 1'b1);
      if (VECS[i].cls == 2'd1) begin
        if (VECS[i].exp_exec) begin
          chk("R5 exec count", exec_cnt - e0, 1);
          chk("R5 exec op", {24'h0, last_op}, {24'h0, VECS[i].op});
          chk("R2 exec addr", {8'h0, last_addr}, {8'h0, VECS[i].ad});
          chk("R5 exec len", {16'h0, last_len}, {28'h0, VECS[i].nb});
        end else begin
          chk("R6 off-boundary reject", exec_cnt - e0, 0);
        end
        chk("R7 write byte count", wr_cnt - w0, int'(VECS[i].nb));
        if (VECS[i].nb != 0)
          chk("R1 last write byte", {24'h0, last_wr}, {24'h0, 8'h5A + 8'(VECS[i].nb) - 8'h1});
        chk("R8 no drive on modify", {31'h0, oe_seen}, 32'h0);
      end else if (VECS[i].cls == 2'd0) begin
        chk("R3 drove on read", {31'h0, oe_seen}, 32'h1);
        chk(VECS[i].extra != 0 ? "R4 cut read no exec" : "R3 read no exec", exec_cnt - e0, 0);
      end else begin
        chk("R12 unknown no exec", exec_cnt - e0, 0);
        chk("R12 unknown no write", wr_cnt - w0, 0);
        chk("R12 unknown no drive", {31'h0, oe_seen}, 32'h0);
      end
      chk("R8 released after cs", {30'h0, dq_oe_o}, 32'h0);
    end

    // R9 off-boundary entry has no effect
    run_frame(8'hB9, 1'b0, 2'd1, 24'h0, 0, 1, 1'b0);
    chk("R9 off-boundary entry", {31'h0, dpd_o}, 32'h0);
    // R9 clean entry
    e0 = exec_cnt;
    run_frame(8'hB9, 1'b0, 2'd1, 24'h0, 0, 0, 1'b0);
    chk("R9 dpd set", {31'h0, dpd_o}, 32'h1);
    chk("R9 no exec on entry", exec_cnt - e0, 0);
    // R10 commands ignored while powered down
    e0 = exec_cnt; w0 = wr_cnt;
    run_frame(8'hA2, 1'b1, 2'd1, 24'h000100, 2, 0, 1'b0);
    chk("R10 no exec in dpd", exec_cnt - e0, 0);
    chk("R10 no write in dpd", wr_cnt - w0, 0);
    run_frame(8'h05, 1'b0, 2'd0, 24'h0, 1, 0, 1'b0);
    chk("R10 no drive in dpd", {31'h0, oe_seen}, 32'h0);
    chk("R10 still dpd", {31'h0, dpd_o}, 32'h1);
    // R11 release
    run_frame(8'hAB, 1'b0, 2'd1, 24'h0, 0, 2, 1'b0);
    chk("R11 off-boundary release", {31'h0, dpd_o}, 32'h1);
    run_frame(8'hAB, 1'b0, 2'd1, 24'h0, 0, 0, 1'b0);
    chk("R11 released", {31'h0, dpd_o}, 32'h0);
    e0 = exec_cnt;
    run_frame(8'h06, 1'b0, 2'd1, 24'h0, 0, 0, 1'b0);
    chk("R11 exec after release", exec_cnt - e0, 1);
    // R4 read cut mid-byte followed by a normal read
    run_frame(8'hBB, 1'b1, 2'd0, 24'h000040, 1, 3, 1'b1);
    chk("R4 released after cut", {30'h0, dq_oe_o}, 32'h0);
    run_frame(8'hBB, 1'b1, 2'd0, 24'h0000A0, 2, 0, 1'b1);
    chk("R4 next read drove", {31'h0, oe_seen}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule